// File: doc/BRIEF.md
# Interpolated Reciprocal Table Divider

This block divides an unsigned numerator by an unsigned denominator in a fully pipelined datapath. It takes one operand pair per clock and returns one quotient per clock, five cycles later, in issue order. There is no iterative recurrence. A coarse table, indexed by the upper denominator bits, supplies an approximate reciprocal. A second table, indexed by the same bits, supplies the chord slope of the reciprocal across that segment. A small multiplier scales the slope by the denominator's low bits, and the result is subtracted from the table value to give a corrected reciprocal. A wide multiplier then forms numerator times corrected reciprocal, and a round-half-up shift turns that product into the quotient.

Both tables are computed at elaboration by constant functions. A zero denominator returns an all-ones quotient together with an error flag that travels with that result. With the default widths, the table covers denominators from 128 upward. Accuracy improves as the denominator grows, so the block is aimed at datapaths whose divisors stay well away from zero.

Top module: `recip_interp_div`

## Requirements
- R1: Every cycle in which valid_i is high is accepted, including back-to-back cycles. Its result appears with valid_o high exactly 5 rising clock edges later, in issue order. A cycle in which valid_i is low produces a cycle with valid_o low.
- R2: While rst_n is low, and after release until the first result, valid_o and err_o are 0 and quot_o is 0.
- R3: For a denominator d of 2048 or more and a numerator n, quot_o lies between floor(n/d) and floor(n/d)+1 inclusive.
- R4: For 128 <= d < 2048, quot_o lies between floor(n/d) and floor(n/d) + 1 + ceil(n*4096/(d0*d0*d)), where d0 is d with its 7 low bits cleared. The denominator's bits [16:7] select the table segment and bits [6:0] are the offset into it.
- R5: A zero denominator gives quot_o = 16'hFFFF with err_o high in the same cycle as its valid_o. err_o is low for every nonzero denominator and whenever valid_o is low.
- R6: A zero numerator with any nonzero denominator gives quot_o = 0.
- R7: quot_o holds its previous value in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Operand pair present this cycle |
| num_i | input | 17 | Unsigned numerator |
| den_i | input | 17 | Unsigned denominator |
| valid_o | output | 1 | Quotient present this cycle |
| quot_o | output | 16 | Rounded unsigned quotient |
| err_o | output | 1 | Result came from a zero denominator |

## Verification
The bench builds the block with its default parameters: 17-bit operands, a 16-bit quotient, 10 index bits (segments of 128), 18-bit table words, reciprocal scale 24 and slope scale 8. These values bring within reach the last table entry at a denominator of 131071, the first full segment at 128 where chord error is largest, and the 2048 threshold where the tight bound starts. They also keep the quotient under 2048, so the numerator's full range can be streamed without saturation hiding errors. A behavioural model keeps five cycles of issued operands and checks the valid timing, the error flag and the bound that applies on every clock.

// File: rtl/rid_pkg.sv
package rid_pkg;

  // Reciprocal at the start of segment idx, scaled by 2**k and rounded.
  // Entry zero has no finite value and is clamped to the largest word.
  function automatic logic [63:0] recip_word(input int idx, input int seg_w,
                                             input int k, input int word_w);
    logic [63:0] lim;
    logic [63:0] d0;
    logic [63:0] v;
    lim = (64'd1 << word_w) - 64'd1;
    if (idx == 0) return lim;
    d0 = 64'(idx) << seg_w;
    v  = ((64'd1 << k) + (d0 >> 1)) / d0;
    return (v > lim) ? lim : v;
  endfunction

  // Chord slope magnitude per denominator LSB across segment idx,
  // scaled by 2**(k+s) and rounded.
  function automatic logic [63:0] slope_word(input int idx, input int seg_w,
                                             input int k, input int s,
                                             input int word_w);
    logic [63:0] lim;
    logic [63:0] d0;
    logic [63:0] pr;
    logic [63:0] v;
    lim = (64'd1 << word_w) - 64'd1;
    if (idx == 0) return 64'd0;
    d0 = 64'(idx) << seg_w;
    pr = d0 * (d0 + (64'd1 << seg_w));
    v  = ((64'd1 << (k + s)) + (pr >> 1)) / pr;
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/rid_rom.sv
module rid_rom #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18,
  parameter int SEG_W  = 7,
  parameter int K      = 24,
  parameter int S      = 8,
  parameter bit SLOPE  = 1'b0
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] tbl [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
    if (SLOPE) begin : g_slope
      assign tbl[gi] = WORD_W'(rid_pkg::slope_word(gi, SEG_W, K, S, WORD_W));
    end else begin : g_recip
      assign tbl[gi] = WORD_W'(rid_pkg::recip_word(gi, SEG_W, K, WORD_W));
    end
  end

  always_ff @(posedge clk) begin
    if (en_i) data_o <= tbl[addr_i];
  end
endmodule

// File: rtl/rid_interp.sv
module rid_interp #(
  parameter int SEG_W  = 7,
  parameter int WORD_W = 18,
  parameter int S      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a_i,
  input  logic              en_b_i,
  input  logic [SEG_W-1:0]  off_i,
  input  logic [WORD_W-1:0] slope_i,
  input  logic [WORD_W-1:0] base_i,
  output logic [WORD_W-1:0] rc_o
);
  localparam int MUL_W = SEG_W + WORD_W;

  logic [MUL_W-1:0]  corr_n, corr_q;
  logic [WORD_W-1:0] base_q;
  logic [WORD_W-1:0] rc_n;

  always_comb begin
    corr_n = MUL_W'(off_i) * MUL_W'(slope_i);
    rc_n   = base_q - WORD_W'(corr_q >> S);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q <= '0;
      base_q <= '0;
      rc_o   <= '0;
    end else begin
      if (en_a_i) begin
        corr_q <= corr_n;
        base_q <= base_i;
      end
      if (en_b_i) rc_o <= rc_n;
    end
  end

  // R4: the correction never takes the reciprocal below zero (no wrap)
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_b_i) |-> (rc_o <= $past(base_q)));
endmodule

// File: rtl/rid_quot.sv
module rid_quot #(
  parameter int NUM_W  = 17,
  parameter int WORD_W = 18,
  parameter int Q_W    = 16,
  parameter int K      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a_i,
  input  logic              v_i,
  input  logic              zero_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [WORD_W-1:0] rc_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [Q_W-1:0]    quot_o
);
  localparam int PROD_W = NUM_W + WORD_W;
  localparam int RND_W  = PROD_W + 1 - K;

  logic [PROD_W-1:0] prod_n, prod_q;
  logic [PROD_W:0]   sum;
  logic [RND_W-1:0]  rnd;
  logic [Q_W-1:0]    qval;
  logic [Q_W-1:0]    quot_n;

  always_comb begin
    prod_n = PROD_W'(num_i) * PROD_W'(rc_i);
    sum    = {1'b0, prod_q} + ((PROD_W + 1)'(1) << (K - 1));
    rnd    = RND_W'(sum >> K);
  end

  if (RND_W > Q_W) begin : g_sat
    always_comb qval = (|rnd[RND_W-1:Q_W]) ? '1 : rnd[Q_W-1:0];
  end else begin : g_nosat
    always_comb qval = Q_W'(rnd);
  end

  always_comb quot_n = zero_i ? '1 : qval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      quot_o  <= '0;
    end else begin
      if (en_a_i) prod_q <= prod_n;
      valid_o <= v_i;
      err_o   <= v_i & zero_i;
      if (v_i) quot_o <= quot_n;
    end
  end

  // R7: the quotient is held whenever no result is presented
  p_hold_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(quot_o));
  // R6: zero numerator with a nonzero denominator yields zero
  p_zero_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o && $past(en_a_i, 2) && $past(num_i == '0, 2))
      |-> (quot_o == '0));
endmodule

// File: rtl/rid_delay.sv
module rid_delay #(
  parameter int W     = 17,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] en_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_head
      assign src = d_i;
    end else begin : g_body
      assign src = pipe[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe[g] <= '0;
      else if (en_i[g]) pipe[g] <= src;
    end
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/recip_interp_div.sv
module recip_interp_div #(
  parameter int NUM_W  = 17,
  parameter int DEN_W  = 17,
  parameter int Q_W    = 16,
  parameter int IDX_W  = 10,
  parameter int WORD_W = 18,
  parameter int K      = 24,
  parameter int S      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [Q_W-1:0]   quot_o,
  output logic             err_o
);
  localparam int SEG_W = DEN_W - IDX_W;
  localparam int LAT   = 5;
  localparam int VD    = LAT - 1;

  logic [VD-1:0]     v_q;
  logic [SEG_W-1:0]  off_q;
  logic [WORD_W-1:0] base_w, slope_w, rc_w;
  logic [NUM_W-1:0]  num_w;
  logic              zero_w;
  logic              den_zero;

  assign den_zero = (den_i == '0);

  // stage valid chain; stage g is enabled by the valid entering it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[VD-2:0], valid_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       off_q <= '0;
    else if (valid_i) off_q <= den_i[SEG_W-1:0];
  end

  rid_rom #(.ADDR_W(IDX_W), .WORD_W(WORD_W), .SEG_W(SEG_W), .K(K), .S(S),
            .SLOPE(1'b0)) u_recip_rom (
    .clk(clk), .en_i(valid_i), .addr_i(den_i[DEN_W-1:SEG_W]), .data_o(base_w));

  rid_rom #(.ADDR_W(IDX_W), .WORD_W(WORD_W), .SEG_W(SEG_W), .K(K), .S(S),
            .SLOPE(1'b1)) u_slope_rom (
    .clk(clk), .en_i(valid_i), .addr_i(den_i[DEN_W-1:SEG_W]), .data_o(slope_w));

  rid_interp #(.SEG_W(SEG_W), .WORD_W(WORD_W), .S(S)) u_interp (
    .clk(clk), .rst_n(rst_n), .en_a_i(v_q[0]), .en_b_i(v_q[1]),
    .off_i(off_q), .slope_i(slope_w), .base_i(base_w), .rc_o(rc_w));

  rid_delay #(.W(NUM_W), .DEPTH(3)) u_num_dly (
    .clk(clk), .rst_n(rst_n), .en_i({v_q[1], v_q[0], valid_i}),
    .d_i(num_i), .q_o(num_w));

  rid_delay #(.W(1), .DEPTH(4)) u_zero_dly (
    .clk(clk), .rst_n(rst_n), .en_i({v_q[2], v_q[1], v_q[0], valid_i}),
    .d_i(den_zero), .q_o(zero_w));

  rid_quot #(.NUM_W(NUM_W), .WORD_W(WORD_W), .Q_W(Q_W), .K(K)) u_quot (
    .clk(clk), .rst_n(rst_n), .en_a_i(v_q[2]), .v_i(v_q[3]), .zero_i(zero_w),
    .num_i(num_w), .rc_i(rc_w), .valid_o(valid_o), .err_o(err_o),
    .quot_o(quot_o));

  // cycles since reset, so the latency check never reaches into reset
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_rst <= '0;
    else if (since_rst != 3'(LAT)) since_rst <= since_rst + 3'd1;
  end

  // R1: each accepted pair returns exactly five edges later
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'(LAT)) |-> (valid_o == $past(valid_i, 5)));
  // R5: the error flag only rides on a presented result
  p_err_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);
  // R5: a flagged result carries the all-ones quotient
  p_err_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_o) |-> (quot_o == '1));
endmodule

// File: tb/recip_interp_div_bench.sv
module recip_interp_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [16:0] num_i = '0;
  logic [16:0] den_i = '0;
  logic        valid_o;
  logic [15:0] quot_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit hv [5];
  int hn [5];
  int hd [5];
  int last_q = 0;

  always #4 clk = ~clk;

  recip_interp_div u_recip_interp_div (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .num_i(num_i), .den_i(den_i),
    .valid_o(valid_o), .quot_o(quot_o), .err_o(err_o));

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    chk(valid_o === hv[4], "R1 valid_o timing", valid_o, hv[4]);
    if (hv[4]) begin
      longint n = hn[4];
      longint d = hd[4];
      longint q = quot_o;
      if (d == 0) begin
        chk(quot_o === 16'hFFFF && err_o === 1'b1, "R5 zero denominator",
            {err_o, quot_o}, 32'h1FFFF);
      end else begin
        chk(err_o === 1'b0, "R5 err_o low for nonzero d", err_o, 0);
        if (n == 0) begin
          chk(q == 0, "R6 zero numerator", q, 0);
        end else if (d >= 2048) begin
          longint fl = n / d;
          chk(q >= fl && q <= fl + 1, "R3 tight bound", q, fl);
        end else if (d >= 128) begin
          longint fl = n / d;
          longint d0 = d & ~longint'(127);
          longint den3 = d0 * d0 * d;
          longint tol = 1 + (n * 4096 + den3 - 1) / den3;
          chk(q >= fl && q <= fl + tol, "R4 segment bound", q, fl);
        end
      end
      last_q = quot_o;
    end else begin
      chk(err_o === 1'b0, "R5 err_o low when idle", err_o, 0);
      chk(quot_o == last_q, "R7 quot_o held", quot_o, last_q);
    end
  endtask

  task automatic step(input bit v, input int n, input int d);
    @(negedge clk);
    check_outputs();
    for (int i = 4; i > 0; i--) begin
      hv[i] = hv[i-1]; hn[i] = hn[i-1]; hd[i] = hd[i-1];
    end
    hv[0] = v; hn[0] = n; hd[0] = d;
    valid_i = v;
    num_i = 17'(n);
    den_i = 17'(d);
  endtask

  function automatic int rand_den();
    int sel = $urandom_range(0, 15);
    if (sel == 0)      return 0;
    else if (sel == 1) return $urandom_range(1, 127);
    else if (sel < 6)  return $urandom_range(128, 2047);
    else               return $urandom_range(2048, 131071);
  endfunction

  function automatic int rand_num();
    if ($urandom_range(0, 19) == 0) return 0;
    return $urandom_range(0, 131071);
  endfunction

  initial begin
    for (int i = 0; i < 5; i++) begin hv[i] = 0; hn[i] = 0; hd[i] = 0; end
    repeat (3) @(negedge clk);
    // R2: outputs cleared while in reset
    chk(valid_o === 1'b0, "R2 valid_o in reset", valid_o, 0);
    chk(err_o === 1'b0, "R2 err_o in reset", err_o, 0);
    chk(quot_o === 16'h0, "R2 quot_o in reset", quot_o, 0);
    rst_n = 1'b1;
    // R2: still clear before the first result
    repeat (3) step(0, 0, 0);
    chk(valid_o === 1'b0 && quot_o === 16'h0, "R2 quiet after release",
        quot_o, 0);

    // directed corners, issued back to back (R1, R3, R4, R5, R6)
    step(1, 0, 0);
    step(1, 131071, 0);
    step(1, 131071, 2048);
    step(1, 131071, 131071);
    step(1, 0, 5000);
    step(1, 0, 1);
    step(1, 100000, 65535);
    step(1, 131071, 2047);
    step(1, 131071, 128);
    step(1, 131071, 191);
    step(1, 65536, 4096);
    step(1, 12345, 131071);
    step(1, 131070, 65535);
    step(1, 131071, 2175);
    step(1, 99999, 130944);
    repeat (6) step(0, 0, 0);

    // R1: long back-to-back stream with no bubbles
    for (int i = 0; i < 1500; i++) step(1, rand_num(), rand_den());
    // R1, R7: sparse issue with idle gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 1) step(1, rand_num(), rand_den());
      else                           step(0, rand_num(), rand_den());
    end
    repeat (8) step(0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule